// File: doc/BRIEF.md
# Endpoint-0 Control Status Register

This block is the status and control byte that a local microcontroller uses to follow the default control endpoint of a USB device controller. It records the arrival of a valid 8-byte setup packet, holds the endpoint-0 receive FIFO locked until firmware has read the setup bytes and acknowledged them, and drives a level interrupt request while the setup flag is pending and interrupts are enabled.

Firmware acknowledges a setup packet by writing 1 to bit 0 of the register. During a control-write transfer that acknowledgement also emits a one-cycle strobe that clears the endpoint's packet-ready flag and releases the FIFO lock, so that data-stage packets can be received. The block also keeps a stall flag that hardware sets when a data-stage packet is too long or ends without an end-of-packet marker, and it reports the current control-transfer stage as a 2-bit code. Packet decoding, the FIFOs and the stage sequencer are outside the block and appear only as input strobes and a stage input.

Top module: `ep0_status_reg`

## Requirements
- R1: After the asynchronous hardware reset, every state bit is 0: the register reads 0x00 at read address 0xF3, and `irq`, `fifo_lock` and `pkt_rdy_clr` are 0. Any read address other than `RD_ADDR` returns 0x00 with `rd_hit` low.
- R2: A `setup_cap` pulse sets setup-ready (bit 0) and `fifo_lock` at the next clock edge. If a `setup_cap` pulse and an acknowledgement arrive in the same cycle, the set wins.
- R3: A write to address 0x73 with bit 0 = 1 clears setup-ready at the next edge. A write with bit 0 = 0, or a write to any other address, leaves setup-ready unchanged.
- R4: `irq` is registered. In cycle t+1 it equals setup-ready ANDed with `irq_en`, both taken in cycle t.
- R5: When setup-ready is actually cleared by an acknowledgement while `ctrl_write` = 1, `pkt_rdy_clr` is 1 for exactly the cycle in which bit 0 first reads 0, and `fifo_lock` drops at the same time. With `ctrl_write` = 0 the acknowledgement produces no strobe, and the lock stays set until `stage_in` shows the status stage (2'b10) with no new setup capture.
- R6: Hardware sets the stall flag (bit 2) at the next edge when `pkt_done` = 1, `ctrl_write` = 1, `stage_in` = 2'b01 (data), and either `pkt_len` > `max_pld` or `pkt_eop` = 0.
- R7: A write to 0x73 loads the stall flag from bit 2 of the write data. A hardware stall set in the same cycle as a firmware write of 0 leaves the flag at 1.
- R8: Bits 4:3 report `stage_in` registered one cycle: 00 setup, 01 data, 10 status.
- R9: Bits 7:5 and bit 1 always read 0. Writing 1 to them changes no state bit.
- R10: A `bus_rst` pulse clears setup-ready, the stall flag, the stage field, `fifo_lock`, `irq` and `pkt_rdy_clr` at the next edge. It takes priority over every set request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| bus_rst | input | 1 | Synchronous USB bus reset |
| rd_addr | input | ADDR_W | Register read address |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 8 | Register write data |
| irq_en | input | 1 | Setup interrupt enable (bit 0 of the interrupt-enable register) |
| setup_cap | input | 1 | Pulse: a valid 8-byte setup packet was captured |
| ctrl_write | input | 1 | Current control transfer is a control write |
| stage_in | input | 2 | Stage code from the stage sequencer |
| pkt_done | input | 1 | Pulse: endpoint-0 data packet reception finished |
| pkt_eop | input | 1 | The finished packet ended with end-of-packet |
| pkt_len | input | LEN_W | Byte count of the finished packet |
| max_pld | input | LEN_W | Endpoint-0 receive maximum payload size |
| rd_data | output | 8 | Read data, 0 when the read address does not match |
| rd_hit | output | 1 | Read address matches this register |
| fifo_lock | output | 1 | Endpoint-0 receive FIFO lock |
| pkt_rdy_clr | output | 1 | One-cycle strobe that clears the endpoint-0 packet-ready flag |
| irq | output | 1 | Level interrupt request |

## Verification
The bound checker checks the following rules on every cycle: the set-over-clear priority of setup-ready, clearing by a 1-write, holding on a 0-write, the one-cycle interrupt lag, the strobe lining up with the falling setup flag, the hardware stall set, the zero reserved bits and the bus-reset clear. Some behaviour can only be shown by the bench's scenarios, where a cycle-level reference model is compared with the read-back byte and outputs: the lock that persists through a control read until the status stage, the firmware-written stall value losing to a simultaneous hardware set, the oversize comparison against a chosen payload limit, and address decoding against random addresses.

// File: rtl/ep0s_pkg.sv
package ep0s_pkg;

  typedef enum logic [1:0] {
    STG_SETUP  = 2'b00,
    STG_DATA   = 2'b01,
    STG_STATUS = 2'b10,
    STG_RSVD   = 2'b11
  } ep0_stage_e;

  localparam int BIT_SETUP = 0;
  localparam int BIT_STALL = 2;
  localparam int STG_LSB   = 3;

  // Oversize test on zero-extended byte counts.
  function automatic logic pkt_too_long(input logic [15:0] len, input logic [15:0] lim);
    return len > lim;
  endfunction

  // A data-stage packet is bad if it is too long or has no end-of-packet.
  function automatic logic pkt_is_bad(input logic too_long, input logic eop_seen);
    return too_long || !eop_seen;
  endfunction

  // Assemble the register byte; reserved bits stay 0.
  function automatic logic [7:0] pack_image(input logic setup, input logic stall,
                                            input logic [1:0] stage);
    logic [7:0] img;
    img = 8'h00;
    img[BIT_SETUP] = setup;
    img[BIT_STALL] = stall;
    img[STG_LSB +: 2] = stage;
    return img;
  endfunction

endpackage

// File: rtl/ep0s_bus_if.sv
module ep0s_bus_if #(
  parameter int          ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] RD_ADDR = 8'hF3,
  parameter logic [ADDR_W-1:0] WR_ADDR = 8'h73
) (
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [7:0]        image,
  output logic [7:0]        rd_data,
  output logic              rd_hit,
  output logic              wr_hit,
  output logic              ack_req,
  output logic              wr_stall_val
);
  import ep0s_pkg::*;

  always_comb begin
    rd_hit       = (rd_addr == RD_ADDR);
    rd_data      = rd_hit ? image : 8'h00;
    wr_hit       = wr_en && (wr_addr == WR_ADDR);
    ack_req      = wr_hit && wr_data[BIT_SETUP];
    wr_stall_val = wr_data[BIT_STALL];
  end

endmodule

// File: rtl/ep0s_setup_ctl.sv
module ep0s_setup_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_rst,
  input  logic       setup_set,
  input  logic       ack_req,
  input  logic       ctrl_write,
  input  logic [1:0] stage_now,
  input  logic       irq_en,
  output logic       setup_rdy,
  output logic       fifo_lock,
  output logic       pkt_rdy_clr,
  output logic       irq,
  output logic       setup_clr_evt
);
  import ep0s_pkg::*;

  logic lock_release;

  always_comb begin
    setup_clr_evt = setup_rdy && ack_req && !setup_set;
    lock_release  = (setup_clr_evt && ctrl_write) ||
                    (stage_now == STG_STATUS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setup_rdy   <= 1'b0;
      fifo_lock   <= 1'b0;
      pkt_rdy_clr <= 1'b0;
      irq         <= 1'b0;
    end else if (bus_rst) begin
      setup_rdy   <= 1'b0;
      fifo_lock   <= 1'b0;
      pkt_rdy_clr <= 1'b0;
      irq         <= 1'b0;
    end else begin
      irq         <= setup_rdy && irq_en;
      pkt_rdy_clr <= setup_clr_evt && ctrl_write;
      if (setup_set)          setup_rdy <= 1'b1;
      else if (setup_clr_evt) setup_rdy <= 1'b0;
      if (setup_set)          fifo_lock <= 1'b1;
      else if (lock_release)  fifo_lock <= 1'b0;
    end
  end

endmodule

// File: rtl/ep0s_stall_ctl.sv
module ep0s_stall_ctl #(
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_rst,
  input  logic             pkt_done,
  input  logic             pkt_eop,
  input  logic [LEN_W-1:0] pkt_len,
  input  logic [LEN_W-1:0] max_pld,
  input  logic             ctrl_write,
  input  logic [1:0]       stage_now,
  input  logic             wr_hit,
  input  logic             wr_stall_val,
  output logic             stall,
  output logic             hw_stall_evt
);
  import ep0s_pkg::*;

  logic too_long;

  always_comb begin
    too_long     = pkt_too_long(16'(pkt_len), 16'(max_pld));
    hw_stall_evt = pkt_done && ctrl_write && (stage_now == STG_DATA) &&
                   pkt_is_bad(too_long, pkt_eop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            stall <= 1'b0;
    else if (bus_rst)      stall <= 1'b0;
    else if (hw_stall_evt) stall <= 1'b1;
    else if (wr_hit)       stall <= wr_stall_val;
  end

endmodule

// File: rtl/ep0s_stage_reg.sv
module ep0s_stage_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_rst,
  input  logic [1:0] stage_in,
  output logic [1:0] stage_q
);
  import ep0s_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stage_q <= STG_SETUP;
    else if (bus_rst) stage_q <= STG_SETUP;
    else              stage_q <= stage_in;
  end

endmodule

// File: rtl/ep0_status_reg.sv
module ep0_status_reg #(
  parameter int          ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] RD_ADDR = 8'hF3,
  parameter logic [ADDR_W-1:0] WR_ADDR = 8'h73,
  parameter int          LEN_W   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rst,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              irq_en,
  input  logic              setup_cap,
  input  logic              ctrl_write,
  input  logic [1:0]        stage_in,
  input  logic              pkt_done,
  input  logic              pkt_eop,
  input  logic [LEN_W-1:0]  pkt_len,
  input  logic [LEN_W-1:0]  max_pld,
  output logic [7:0]        rd_data,
  output logic              rd_hit,
  output logic              fifo_lock,
  output logic              pkt_rdy_clr,
  output logic              irq
);
  import ep0s_pkg::*;

  logic       setup_rdy;
  logic       stall;
  logic [1:0] stage_q;
  logic [7:0] image;
  logic       wr_hit;
  logic       ack_req;
  logic       wr_stall_val;
  logic       setup_clr_evt;
  logic       hw_stall_evt;

  assign image = pack_image(setup_rdy, stall, stage_q);

  ep0s_bus_if #(
    .ADDR_W (ADDR_W),
    .RD_ADDR(RD_ADDR),
    .WR_ADDR(WR_ADDR)
  ) u_bus (
    .rd_addr     (rd_addr),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .image       (image),
    .rd_data     (rd_data),
    .rd_hit      (rd_hit),
    .wr_hit      (wr_hit),
    .ack_req     (ack_req),
    .wr_stall_val(wr_stall_val)
  );

  ep0s_setup_ctl u_setup (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_rst      (bus_rst),
    .setup_set    (setup_cap),
    .ack_req      (ack_req),
    .ctrl_write   (ctrl_write),
    .stage_now    (stage_in),
    .irq_en       (irq_en),
    .setup_rdy    (setup_rdy),
    .fifo_lock    (fifo_lock),
    .pkt_rdy_clr  (pkt_rdy_clr),
    .irq          (irq),
    .setup_clr_evt(setup_clr_evt)
  );

  ep0s_stall_ctl #(.LEN_W(LEN_W)) u_stall (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_rst     (bus_rst),
    .pkt_done    (pkt_done),
    .pkt_eop     (pkt_eop),
    .pkt_len     (pkt_len),
    .max_pld     (max_pld),
    .ctrl_write  (ctrl_write),
    .stage_now   (stage_in),
    .wr_hit      (wr_hit),
    .wr_stall_val(wr_stall_val),
    .stall       (stall),
    .hw_stall_evt(hw_stall_evt)
  );

  ep0s_stage_reg u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_rst (bus_rst),
    .stage_in(stage_in),
    .stage_q (stage_q)
  );

endmodule

// File: rtl/ep0_status_chk.sv
module ep0_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_rst,
  input logic       setup_cap,
  input logic       ack_req,
  input logic       wr_hit,
  input logic [7:0] wr_data,
  input logic       irq_en,
  input logic       setup_rdy,
  input logic       stall,
  input logic [1:0] stage_q,
  input logic       irq,
  input logic       pkt_rdy_clr,
  input logic       hw_stall_evt,
  input logic [7:0] rd_data
);

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_cap && !bus_rst) |=> setup_rdy);                          // R2

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && !setup_cap) |=> !setup_rdy);                         // R3

  AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !wr_data[0] && !setup_cap && !bus_rst) |=> $stable(setup_rdy)); // R3

  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rst |=> (irq == ($past(setup_rdy) && $past(irq_en))));      // R4

  AST_STROBE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_rdy_clr |-> $fell(setup_rdy));                                // R5

  AST_HW_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_stall_evt && !bus_rst) |=> stall);                            // R6

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[7:5] == 3'b000) && !rd_data[1]);                         // R9

  AST_BUS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> (!setup_rdy && !stall && (stage_q == 2'b00) && !irq && !pkt_rdy_clr)); // R10

endmodule

bind ep0_status_reg ep0_status_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_rst     (bus_rst),
  .setup_cap   (setup_cap),
  .ack_req     (ack_req),
  .wr_hit      (wr_hit),
  .wr_data     (wr_data),
  .irq_en      (irq_en),
  .setup_rdy   (setup_rdy),
  .stall       (stall),
  .stage_q     (stage_q),
  .irq         (irq),
  .pkt_rdy_clr (pkt_rdy_clr),
  .hw_stall_evt(hw_stall_evt),
  .rd_data     (rd_data)
);

// File: tb/ep0_status_reg_tb.sv
module ep0_status_reg_tb;

  localparam int CLK_NS = 10;
  localparam int LEN_W  = 7;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             bus_rst = 1'b0;
  logic [7:0]       rd_addr = 8'hF3;
  logic             wr_en = 1'b0;
  logic [7:0]       wr_addr = 8'h00;
  logic [7:0]       wr_data = 8'h00;
  logic             irq_en = 1'b0;
  logic             setup_cap = 1'b0;
  logic             ctrl_write = 1'b0;
  logic [1:0]       stage_in = 2'b00;
  logic             pkt_done = 1'b0;
  logic             pkt_eop = 1'b1;
  logic [LEN_W-1:0] pkt_len = '0;
  logic [LEN_W-1:0] max_pld = 7'd8;
  logic [7:0]       rd_data;
  logic             rd_hit;
  logic             fifo_lock;
  logic             pkt_rdy_clr;
  logic             irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference state
  bit       m_setup, m_stall, m_lock, m_pclr, m_irq;
  bit [1:0] m_stage;

  always #(CLK_NS/2) clk = ~clk;

  ep0_status_reg u_dut (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .irq_en(irq_en),
    .setup_cap(setup_cap), .ctrl_write(ctrl_write), .stage_in(stage_in),
    .pkt_done(pkt_done), .pkt_eop(pkt_eop), .pkt_len(pkt_len), .max_pld(max_pld),
    .rd_data(rd_data), .rd_hit(rd_hit), .fifo_lock(fifo_lock),
    .pkt_rdy_clr(pkt_rdy_clr), .irq(irq)
  );

  function automatic bit [7:0] exp_byte(bit s, bit st, bit [1:0] sg);
    return {3'b000, sg, st, 1'b0, s};
  endfunction

  function automatic bit bad_packet();
    return pkt_done && ctrl_write && (stage_in == 2'b01) &&
           ((pkt_len > max_pld) || !pkt_eop);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit [7:0] e;
    e = (rd_addr == 8'hF3) ? exp_byte(m_setup, m_stall, m_stage) : 8'h00;
    chk("R1 rd_hit decode", rd_hit, rd_addr == 8'hF3);
    chk("R2 R3 setup-ready bit0", rd_data[0], e[0]);
    chk("R6 R7 stall bit2", rd_data[2], e[2]);
    chk("R8 stage bits4:3", rd_data[4:3], e[4:3]);
    chk("R9 reserved bits", {rd_data[7:5], rd_data[1]}, 0);
    chk("R4 irq", irq, m_irq);
    chk("R2 R5 fifo_lock", fifo_lock, m_lock);
    chk("R5 pkt_rdy_clr", pkt_rdy_clr, m_pclr);
  endtask

  // Apply current inputs for one clock, update the model, compare.
  task automatic step();
    bit whit, ack, eff;
    bit n_setup, n_stall, n_lock, n_pclr, n_irq;
    bit [1:0] n_stage;
    whit = wr_en && (wr_addr == 8'h73);
    ack  = whit && wr_data[0];
    eff  = m_setup && ack && !setup_cap;
    if (bus_rst) begin
      n_setup = 0; n_stall = 0; n_lock = 0; n_pclr = 0; n_irq = 0; n_stage = 0;
    end else begin
      n_irq   = m_setup && irq_en;
      n_pclr  = eff && ctrl_write;
      n_setup = setup_cap ? 1'b1 : (eff ? 1'b0 : m_setup);
      n_lock  = setup_cap ? 1'b1 :
                (((eff && ctrl_write) || stage_in == 2'b10) ? 1'b0 : m_lock);
      n_stall = bad_packet() ? 1'b1 : (whit ? wr_data[2] : m_stall);
      n_stage = stage_in;
    end
    @(posedge clk);
    #1;
    m_setup = n_setup; m_stall = n_stall; m_lock = n_lock;
    m_pclr = n_pclr; m_irq = n_irq; m_stage = n_stage;
    compare_all();
  endtask

  task automatic idle();
    bus_rst = 0; wr_en = 0; setup_cap = 0; pkt_done = 0; rd_addr = 8'hF3;
  endtask

  task automatic fw_write(input bit [7:0] a, input bit [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_setup = 0; m_stall = 0; m_lock = 0; m_pclr = 0; m_irq = 0; m_stage = 0;
    #(CLK_NS * 2 + 1);
    compare_all();                               // R1 during reset
    rst_n = 1'b1;
    @(negedge clk);
    step();                                      // R1 idle after reset
    rd_addr = 8'h10; #1; compare_all(); rd_addr = 8'hF3;  // R1 other address

    // R2 capture, R4 irq lag
    irq_en = 1; setup_cap = 1; step(); idle(); step(); step();
    // R3 zero-write and foreign address keep
    fw_write(8'h73, 8'hFE); step(); fw_write(8'hF3, 8'h01); step(); idle();
    // R2 set beats simultaneous ack
    setup_cap = 1; fw_write(8'h73, 8'h01); step(); idle();
    // R5 control-write ack: strobe and lock release
    ctrl_write = 1; fw_write(8'h73, 8'h01); step(); idle(); step();
    // R6 oversize and missing EOP in data stage
    stage_in = 2'b01; pkt_done = 1; pkt_len = 7'd9; max_pld = 7'd8; step(); idle();
    fw_write(8'h73, 8'h00); step(); idle();
    pkt_done = 1; pkt_len = 7'd8; pkt_eop = 0; step(); idle(); pkt_eop = 1;
    // R7 firmware write 0 loses to hw set; write 1 works alone
    pkt_done = 1; pkt_len = 7'd20; fw_write(8'h73, 8'h00); step(); idle();
    fw_write(8'h73, 8'h04); step(); idle();
    // R5 control read: no strobe, lock kept until status stage
    ctrl_write = 0; stage_in = 2'b00; setup_cap = 1; step(); idle();
    fw_write(8'h73, 8'h01); step(); idle();
    stage_in = 2'b01; step(); stage_in = 2'b10; step(); stage_in = 2'b00; step();
    // R9 reserved write
    fw_write(8'h73, 8'hE2); step(); idle();
    // R10 bus reset over a set request
    setup_cap = 1; step(); setup_cap = 1; bus_rst = 1; stage_in = 2'b10; step(); idle();

    for (int i = 0; i < 3000; i++) begin
      bus_rst    = ($urandom % 64) == 0;
      rd_addr    = ($urandom % 8 == 0) ? 8'($urandom) : 8'hF3;
      wr_en      = ($urandom % 4) == 0;
      wr_addr    = ($urandom % 5 == 0) ? 8'($urandom) : 8'h73;
      wr_data    = 8'($urandom);
      irq_en     = ($urandom % 4) != 0;
      setup_cap  = ($urandom % 8) == 0;
      ctrl_write = ($urandom % 2) == 0;
      stage_in   = 2'($urandom % 3);
      pkt_done   = ($urandom % 4) == 0;
      pkt_eop    = ($urandom % 4) != 0;
      pkt_len    = 7'($urandom);
      max_pld    = ($urandom % 2) ? 7'd8 : 7'd64;
      step();
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule